// File: doc/BRIEF.md
# Configuration Register Upload Controller

This block owns a 16-bit command and status register and a sequencer that fills internal management registers from up to two external configuration memories. Software writes the upload code into the command field. The sequencer then reads records from the first memory through a simple byte-read port and turns each record into one write on an internal register bus. When the first memory ends or fails, the sequencer handles the second memory in the same way.

Each memory has its own two-bit status field. The field shows live progress while that memory is being read. A completed or failed result is latched and held until software reads the register. The physical two-wire driver sits outside the block. It answers every byte request with an acknowledge that carries data, or with a not-acknowledge.

Every record is four bytes, most significant byte first: the 16-bit target address, then the 16-bit data. A record whose address is 16'hFFFF ends that memory.

Top module: `cfg_upload_ctrl`

## Requirements
- R1: A register write whose bits 1:0 are 2'b11, made while no upload is running, starts an upload. The first byte request goes to memory 0 (`br_mem_sel`=0) at byte address 0, and later requests step through consecutive byte addresses.
- R2: A write with command code 2'b00, 2'b01 or 2'b10 starts nothing. No byte request follows, no register-bus write occurs, and the register keeps reading zero.
- R3: Each record is four bytes: address high, address low, data high, data low. A complete record gives exactly one single-cycle `rb_wr_en` pulse carrying that address and data. An address of 16'hFFFF ends the memory, its two data bytes are not requested, and no write is issued for it.
- R4: Memory 0 is processed to completion before memory 1. Register-bus writes appear in memory order. Bits 5:4 read 2'b00 while memory 0 is still being processed, and the two fields never both read 2'b10.
- R5: The status fields are bits 3:2 for memory 0 and bits 5:4 for memory 1. They are encoded as 00 idle, 01 completed, 10 in progress and 11 failed. A field reads 10 while its memory is being processed.
- R6: A completed (01) or failed (11) result is latched and returned by the next register read. That read clears the latch, so later reads show the live value, which is 00 once the upload is over.
- R7: A not-acknowledge on any byte sets that memory's result to 11. Records completed before it stay written, and the sequencer moves on to the next memory.
- R8: If a byte request receives neither acknowledge nor not-acknowledge for more than `timeout_limit` cycles, that memory's result is 11 and the sequencer moves on.
- R9: A 2'b11 write made while an upload is running is ignored. It does not restart the sequence and does not repeat any register write.
- R10: Bits 1:0 read 2'b11 while an upload is running and 2'b00 once the last memory has ended.
- R11: Bits 15:6 always read zero. After reset the whole register reads zero, and `br_req` and `rb_wr_en` are low.
- R12: The read value is registered. `csr_rd_data` holds the register contents sampled at the clock edge where `csr_rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | 16 | Register write data; bits 1:0 carry the command code |
| csr_rd_en | input | 1 | Register read strobe; clears latched results |
| csr_rd_data | output | 16 | Registered read data |
| timeout_limit | input | TW | Cycles a byte request may wait for a response |
| br_req | output | 1 | Byte request, held until a response or a timeout |
| br_mem_sel | output | 1 | Selects which configuration memory is read |
| br_addr | output | AW | Byte address within the selected memory |
| br_ack | input | 1 | Byte acknowledge; `br_data` is valid in the same cycle |
| br_nack | input | 1 | Byte not-acknowledge |
| br_data | input | 8 | Returned byte |
| rb_wr_en | output | 1 | Register-bus write pulse |
| rb_addr | output | 16 | Register-bus write address |
| rb_data | output | 16 | Register-bus write data |

## Verification
The hardest states to reach from the ports are mid-upload ones: a read that catches the in-progress code, and a second start command arriving while the sequencer is still busy. The bench reaches them by slowing every byte acknowledge, then reading and re-issuing the command a few cycles after the start. Failure paths come from a responder model that can answer one chosen byte address with a not-acknowledge, or stay silent for a whole memory. A sweep over record counts per memory checks the written sequence against images built arithmetically in the bench.

// File: rtl/upl_pkg.sv
package upl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DONE = 2'b01,
    ST_BUSY = 2'b10,
    ST_FAIL = 2'b11
  } upl_stat_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_WAIT
  } sq_state_e;

  localparam logic [1:0]  CMD_UPLOAD = 2'b11;
  localparam logic [15:0] END_MARK   = 16'hFFFF;
endpackage

// File: rtl/upl_byte_fetch.sv
module upl_byte_fetch #(
  parameter int AW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic [TW-1:0] limit,
  input  logic          ack,
  input  logic          nack,
  input  logic [7:0]    data_in,
  output logic          req,
  output logic [AW-1:0] addr_out,
  output logic          done,
  output logic          err,
  output logic [7:0]    byte_out
);
  logic [TW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      addr_out <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      byte_out <= '0;
      wait_cnt <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (start) begin
        req      <= 1'b1;
        addr_out <= addr_in;
        wait_cnt <= '0;
      end else if (req) begin
        if (ack) begin
          req      <= 1'b0;
          done     <= 1'b1;
          byte_out <= data_in;
        end else if (nack || (wait_cnt >= limit)) begin
          req <= 1'b0;
          err <= 1'b1;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/upl_sequencer.sv
module upl_sequencer
  import upl_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NMEM = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_cmd,
  input  logic            fetch_done,
  input  logic            fetch_err,
  input  logic [7:0]      fetch_byte,
  output logic            fetch_start,
  output logic [AW-1:0]   fetch_addr,
  output logic [((NMEM > 1) ? $clog2(NMEM) : 1)-1:0] mem_sel,
  output logic            active,
  output logic [NMEM-1:0] ev_done,
  output logic [NMEM-1:0] ev_fail,
  output logic            rb_wr_en,
  output logic [15:0]     rb_addr,
  output logic [15:0]     rb_data
);
  localparam int MW = (NMEM > 1) ? $clog2(NMEM) : 1;

  sq_state_e     state;
  logic [AW-1:0] ptr;
  logic [1:0]    idx;
  logic [23:0]   shreg;
  logic          fin;
  logic          last_mem;

  assign fetch_start = (state == SQ_REQ);
  assign fetch_addr  = ptr;
  assign last_mem    = (mem_sel == MW'(NMEM - 1));
  assign fin = (state == SQ_WAIT) &&
               (fetch_err || (fetch_done && (idx == 2'd1) &&
                              ({shreg[7:0], fetch_byte} == END_MARK)));

  always_comb begin
    for (int m = 0; m < NMEM; m++) begin
      ev_done[m] = fin && !fetch_err && (mem_sel == MW'(m));
      ev_fail[m] = fin && fetch_err && (mem_sel == MW'(m));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      active   <= 1'b0;
      mem_sel  <= '0;
      ptr      <= '0;
      idx      <= '0;
      shreg    <= '0;
      rb_wr_en <= 1'b0;
      rb_addr  <= '0;
      rb_data  <= '0;
    end else begin
      rb_wr_en <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start_cmd) begin
            active  <= 1'b1;
            mem_sel <= '0;
            ptr     <= '0;
            idx     <= '0;
            state   <= SQ_REQ;
          end
        end
        SQ_REQ: state <= SQ_WAIT;
        SQ_WAIT: begin
          if (fin) begin
            ptr <= '0;
            idx <= '0;
            if (last_mem) begin
              active <= 1'b0;
              state  <= SQ_IDLE;
            end else begin
              mem_sel <= mem_sel + MW'(1);
              state   <= SQ_REQ;
            end
          end else if (fetch_done) begin
            shreg <= {shreg[15:0], fetch_byte};
            ptr   <= ptr + 1'b1;
            idx   <= idx + 2'd1;
            state <= SQ_REQ;
            if (idx == 2'd3) begin
              rb_wr_en <= 1'b1;
              rb_addr  <= shreg[23:8];
              rb_data  <= {shreg[7:0], fetch_byte};
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/upl_stat_latch.sv
module upl_stat_latch
  import upl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] live,
  input  logic       ev_done,
  input  logic       ev_fail,
  input  logic       rd_clr,
  output logic [1:0] field
);
  logic       hold_vld;
  logic [1:0] hold_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_code <= ST_IDLE;
    end else if (ev_fail) begin
      hold_vld  <= 1'b1;
      hold_code <= ST_FAIL;
    end else if (ev_done) begin
      hold_vld  <= 1'b1;
      hold_code <= ST_DONE;
    end else if (rd_clr) begin
      hold_vld <= 1'b0;
    end
  end

  assign field = hold_vld ? hold_code : live;
endmodule

// File: rtl/cfg_upload_ctrl.sv
module cfg_upload_ctrl
  import upl_pkg::*;
#(
  parameter int AW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csr_wr_en,
  input  logic [15:0]   csr_wr_data,
  input  logic          csr_rd_en,
  output logic [15:0]   csr_rd_data,
  input  logic [TW-1:0] timeout_limit,
  output logic          br_req,
  output logic          br_mem_sel,
  output logic [AW-1:0] br_addr,
  input  logic          br_ack,
  input  logic          br_nack,
  input  logic [7:0]    br_data,
  output logic          rb_wr_en,
  output logic [15:0]   rb_addr,
  output logic [15:0]   rb_data
);
  localparam int NMEM = 2;

  logic            start_cmd;
  logic            fetch_start, fetch_done, fetch_err;
  logic [7:0]      fetch_byte;
  logic [AW-1:0]   fetch_addr;
  logic [0:0]      mem_sel;
  logic            seq_active;
  logic [NMEM-1:0] ev_done, ev_fail;
  logic [1:0]      field [NMEM];

  assign start_cmd  = csr_wr_en && (csr_wr_data[1:0] == CMD_UPLOAD);
  assign br_mem_sel = mem_sel[0];

  upl_sequencer #(.AW(AW), .NMEM(NMEM)) seq_i (
    .clk(clk), .rst(rst), .start_cmd(start_cmd),
    .fetch_done(fetch_done), .fetch_err(fetch_err), .fetch_byte(fetch_byte),
    .fetch_start(fetch_start), .fetch_addr(fetch_addr),
    .mem_sel(mem_sel), .active(seq_active),
    .ev_done(ev_done), .ev_fail(ev_fail),
    .rb_wr_en(rb_wr_en), .rb_addr(rb_addr), .rb_data(rb_data)
  );

  upl_byte_fetch #(.AW(AW), .TW(TW)) fetch_i (
    .clk(clk), .rst(rst), .start(fetch_start), .addr_in(fetch_addr),
    .limit(timeout_limit), .ack(br_ack), .nack(br_nack), .data_in(br_data),
    .req(br_req), .addr_out(br_addr), .done(fetch_done), .err(fetch_err),
    .byte_out(fetch_byte)
  );

  for (genvar g = 0; g < NMEM; g++) begin : g_stat
    logic [1:0] live;
    assign live = (seq_active && (mem_sel == 1'(g))) ? ST_BUSY : ST_IDLE;
    upl_stat_latch lat_i (
      .clk(clk), .rst(rst), .live(live),
      .ev_done(ev_done[g]), .ev_fail(ev_fail[g]),
      .rd_clr(csr_rd_en), .field(field[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rd_data <= '0;
    end else if (csr_rd_en) begin
      csr_rd_data <= {10'd0, field[1], field[0],
                      seq_active ? CMD_UPLOAD : 2'b00};
    end
  end
endmodule

// File: rtl/upl_checks.sv
module upl_checks (
  input logic        clk,
  input logic        rst,
  input logic        csr_wr_en,
  input logic [15:0] csr_wr_data,
  input logic [15:0] csr_rd_data,
  input logic        br_req,
  input logic        rb_wr_en,
  input logic        active
);
  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (rst)
    csr_rd_data[15:6] == 10'd0);

  assert_single_busy_R4: assert property (@(posedge clk) disable iff (rst)
    !((csr_rd_data[3:2] == 2'b10) && (csr_rd_data[5:4] == 2'b10)));

  assert_no_start_R2: assert property (@(posedge clk) disable iff (rst)
    (csr_wr_en && (csr_wr_data[1:0] != 2'b11) && !active) |=> !active);

  assert_req_in_upload_R1: assert property (@(posedge clk) disable iff (rst)
    br_req |-> active);

  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rb_wr_en |=> !rb_wr_en);

  assert_wr_in_upload_R3: assert property (@(posedge clk) disable iff (rst)
    rb_wr_en |-> active);
endmodule

bind cfg_upload_ctrl upl_checks chk_i (
  .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
  .csr_rd_data(csr_rd_data), .br_req(br_req), .rb_wr_en(rb_wr_en),
  .active(seq_active)
);

// File: tb/cfg_upload_ctrl_tb_top.sv
module cfg_upload_ctrl_tb_top;
  localparam int AW = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          csr_wr_en = 1'b0;
  logic [15:0]   csr_wr_data = '0;
  logic          csr_rd_en = 1'b0;
  logic [15:0]   csr_rd_data;
  logic [TW-1:0] timeout_limit = 16'd20;
  logic          br_req, br_mem_sel;
  logic [AW-1:0] br_addr;
  logic          br_ack = 1'b0, br_nack = 1'b0;
  logic [7:0]    br_data = '0;
  logic          rb_wr_en;
  logic [15:0]   rb_addr, rb_data;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [7:0]  img [0:1][0:255];
  logic [15:0] exp_a [0:63], exp_d [0:63], got_a [0:63], got_d [0:63];
  int n_exp, n_got;
  int ack_delay, wait_cnt;
  bit nack_en, silent_en;
  logic nack_mem, silent_mem;
  logic [AW-1:0] nack_addr;
  bit saw_req, first_seen;
  logic first_mem;
  logic [AW-1:0] first_addr;

  always #5 clk = ~clk;

  cfg_upload_ctrl #(.AW(AW), .TW(TW)) dut_i (
    .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
    .csr_rd_en(csr_rd_en), .csr_rd_data(csr_rd_data),
    .timeout_limit(timeout_limit), .br_req(br_req), .br_mem_sel(br_mem_sel),
    .br_addr(br_addr), .br_ack(br_ack), .br_nack(br_nack), .br_data(br_data),
    .rb_wr_en(rb_wr_en), .rb_addr(rb_addr), .rb_data(rb_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // byte responder model
  initial begin
    forever begin
      @(negedge clk);
      if (br_req) begin
        saw_req = 1'b1;
        if (!first_seen) begin
          first_seen = 1'b1;
          first_mem  = br_mem_sel;
          first_addr = br_addr;
        end
      end
      if (br_ack || br_nack) begin
        br_ack  = 1'b0;
        br_nack = 1'b0;
      end else if (br_req && !(silent_en && br_mem_sel == silent_mem)) begin
        if (wait_cnt < ack_delay) wait_cnt++;
        else begin
          wait_cnt = 0;
          if (nack_en && br_mem_sel == nack_mem && br_addr == nack_addr) br_nack = 1'b1;
          else begin
            br_ack  = 1'b1;
            br_data = img[br_mem_sel][br_addr];
          end
        end
      end
    end
  end

  // register-bus write monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rb_wr_en && n_got < 64) begin
        got_a[n_got] = rb_addr;
        got_d[n_got] = rb_data;
        n_got++;
      end
    end
  end

  function automatic logic [15:0] rec_addr(int m, int r);
    return 16'h0100 * 16'(m + 1) + 16'(r * 3);
  endfunction
  function automatic logic [15:0] rec_data(int m, int r);
    return 16'hA5C3 ^ 16'(m << 12) ^ 16'(r * 16'h0111);
  endfunction

  // build memory m with n records then a terminator; expect the first nw records
  task automatic build(input int m, input int n, input int nw);
    for (int i = 0; i < 256; i++) img[m][i] = 8'(i * 7 + m);
    for (int r = 0; r < n; r++) begin
      img[m][4*r]   = rec_addr(m, r)[15:8];
      img[m][4*r+1] = rec_addr(m, r)[7:0];
      img[m][4*r+2] = rec_data(m, r)[15:8];
      img[m][4*r+3] = rec_data(m, r)[7:0];
    end
    img[m][4*n]   = 8'hFF;
    img[m][4*n+1] = 8'hFF;
    for (int r = 0; r < nw; r++) begin
      exp_a[n_exp] = rec_addr(m, r);
      exp_d[n_exp] = rec_data(m, r);
      n_exp++;
    end
  endtask

  task automatic csr_write(input logic [15:0] v);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_data = v;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic csr_read(output logic [15:0] v);
    @(negedge clk);
    csr_rd_en = 1'b1;
    @(negedge clk);
    csr_rd_en = 1'b0;
    v = csr_rd_data;
  endtask

  task automatic setup(input int dly);
    n_exp = 0; n_got = 0; ack_delay = dly; wait_cnt = 0;
    nack_en = 1'b0; silent_en = 1'b0; first_seen = 1'b0; saw_req = 1'b0;
  endtask

  task automatic finish_case(input logic [1:0] s0, input logic [1:0] s1, input string tag);
    logic [15:0] r;
    repeat (400) @(negedge clk);
    csr_read(r);
    check(r[1:0] == 2'b00, {"R10 cmd idle ", tag}, r[1:0], 0);
    check(r[3:2] == s0, {"R6/R7 mem0 result ", tag}, r[3:2], s0);
    check(r[5:4] == s1, {"R6/R8 mem1 result ", tag}, r[5:4], s1);
    check(r[15:6] == 0, {"R11 reserved ", tag}, r[15:6], 0);
    csr_read(r);
    check(r == 16'h0000, {"R6 latch cleared ", tag}, r, 0);
    check(n_got == n_exp, {"R3 write count ", tag}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      check(got_a[i] == exp_a[i] && got_d[i] == exp_d[i], {"R4/R3 write order ", tag},
            {got_a[i], got_d[i]}, {exp_a[i], exp_d[i]});
    check(first_seen && first_mem == 1'b0 && first_addr == '0, {"R1 first request ", tag},
          {first_mem, first_addr}, 0);
  endtask

  initial begin
    logic [15:0] r;
    rst = 1'b1;
    setup(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(csr_rd_data == 16'h0000, "R11 reset read data", csr_rd_data, 0);
    check(!br_req && !rb_wr_en, "R11 reset outputs", {br_req, rb_wr_en}, 0);
    csr_read(r);
    check(r == 16'h0000, "R11/R12 reset register", r, 0);

    // reserved command codes
    for (int c = 0; c < 3; c++) begin
      setup(0);
      build(0, 2, 0);
      build(1, 2, 0);
      csr_write(16'(c));
      repeat (30) @(negedge clk);
      check(!saw_req && n_got == 0, "R2 reserved code starts nothing", {saw_req, n_got}, 0);
      csr_read(r);
      check(r == 16'h0000, "R2 register after reserved code", r, 0);
    end

    // sweep of record counts
    for (int n0 = 0; n0 < 4; n0++) begin
      for (int n1 = 0; n1 < 4; n1++) begin
        setup((n0 + n1) % 4);
        build(0, n0, n0);
        build(1, n1, n1);
        csr_write(16'hFFC3);
        finish_case(2'b01, 2'b01, "sweep");
      end
    end

    // in-progress view and ignored restart
    setup(3);
    build(0, 3, 3);
    build(1, 3, 3);
    csr_write(16'h0003);
    repeat (4) @(negedge clk);
    csr_read(r);
    check(r[1:0] == 2'b11, "R10 cmd during upload", r[1:0], 3);
    check(r[3:2] == 2'b10, "R5 mem0 busy", r[3:2], 2);
    check(r[5:4] == 2'b00, "R4 mem1 idle before its turn", r[5:4], 0);
    repeat (10) @(negedge clk);
    csr_write(16'h0003);
    finish_case(2'b01, 2'b01, "R9 restart ignored");

    // not-acknowledge inside record 1 of memory 0
    setup(1);
    build(0, 3, 1);
    build(1, 2, 2);
    nack_en = 1'b1; nack_mem = 1'b0; nack_addr = 8'd6;
    csr_write(16'h0003);
    finish_case(2'b11, 2'b01, "R7 nack");

    // silent memory 1
    setup(2);
    build(0, 2, 2);
    build(1, 2, 0);
    silent_en = 1'b1; silent_mem = 1'b1;
    csr_write(16'h0003);
    finish_case(2'b01, 2'b11, "R8 timeout");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule